// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, in one combinational pass, whether a physical memory access may proceed. A set of protection entries, each with an 8-bit configuration byte and a 32-bit word-granular address register, describes regions of a 34-bit physical space. The access is given as a byte address, a size code, an operation kind and a privilege level. The block returns a single permit bit.

The same entry state also answers a second question for a translation cache. Given a naturally aligned block of `2^REGION_SHIFT` bytes, every entry must place that block either wholly inside or wholly outside its range. If that holds, the permit decision is the same for every byte of the block, and a cached translation may skip the check. Writes to the configuration registers and lock-based write blocking are handled elsewhere. This block only reads the entry state it is given.

Top module: `pmp_guard`

## Requirements
- R1: An entry whose mode field (config bits 4:3) is 0 (off) never matches and never affects the permit or uniformity outputs, whatever its other bits and address register hold.
- R2: Mode 1 (top-of-range) matches byte addresses p with `prev*4 <= p < this*4`. Here `this` is the entry's own address register and `prev` is the address register of the entry below it, whatever that entry's mode. Entry 0 uses 0 as its lower bound.
- R3: Mode 2 matches exactly the 4 bytes starting at `addr_reg*4`.
- R4: Mode 3 matches a naturally aligned region of `8 << k` bytes, where k is the number of trailing one bits of the address register. The region base is `addr_reg*4` with the low bits of the region size cleared. An all-ones register covers the whole space.
- R5: Access size codes 0,1,2,3 mean 1,2,4,8 bytes. If the deciding entry covers some bytes of the access but not all of them, the access is denied.
- R6: When several entries match, the lowest-numbered matching entry alone decides the result.
- R7: Kind codes 0 (load), 1 (store) and 2 (fetch) are permitted by config bits 0 (read), 1 (write) and 2 (execute) of the deciding entry.
- R8: At privilege code 3 (machine), a fully covering entry permits any kind unless its lock bit (config bit 7) is set. With the lock bit set, the bits of R7 apply.
- R9: When no entry matches, privilege 3 is permitted and every other privilege is denied.
- R10: `rgn_uniform` is 1 exactly when each enabled entry has its range empty, wholly containing the block at `rgn_page << REGION_SHIFT`, or wholly disjoint from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | PA_W | Byte address of the access |
| acc_size | input | 2 | Size code: 0..3 for 1,2,4,8 bytes |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| acc_priv | input | 2 | Privilege; 3 is machine |
| ent_cfg_flat | input | NUM_ENT*8 | Config bytes, entry i at bits [8i+7:8i] |
| ent_addr_flat | input | NUM_ENT*(PA_W-2) | Address registers (byte address >> 2), entry i at slice i |
| rgn_page | input | PA_W-REGION_SHIFT | Block number for the uniformity query |
| acc_allow | output | 1 | Access permitted |
| rgn_uniform | output | 1 | Block is uniform over all enabled entries |

## Verification
Because the block holds no state, a wrong intermediate value shows on the outputs as soon as the inputs settle. A mismatched match slice or a bad priority pick flips `acc_allow` for the same input vector. The signs are an off-by-one bound (at the TOR edges), a wrong trailing-ones count (at the NAPOT region edges) or a missed middle granule (on unaligned 8-byte accesses). The sweep walks every byte address, size, kind and privilege across several entry layouts, including overlapping, locked, empty and disabled entries. Any such fault therefore appears at the first address where the faulty boundary differs from the true one. The uniformity output is compared on every block that those addresses touch.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    // Configuration byte layout: lock at bit 7, mode at 4:3, x/w/r at 2:0
    typedef struct packed {
        logic       lock;
        logic [1:0] spare;
        amode_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } ent_cfg_t;

    // Permission bit of a config for a given operation kind
    function automatic logic kind_permitted(ent_cfg_t c, logic [1:0] kind);
        case (kind)
            ACC_LOAD:  return c.r;
            ACC_STORE: return c.w;
            ACC_FETCH: return c.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
    import pmp_pkg::*;
#(
    parameter int PA_W         = 34,
    parameter int REGION_SHIFT = 12
) (
    input  ent_cfg_t              cfg,
    input  logic [PA_W-3:0]       addr_reg,
    input  logic [PA_W-3:0]       prev_reg,
    input  logic [PA_W-1:0]       pt_first,
    input  logic [PA_W-1:0]       pt_mid,
    input  logic                  pt_mid_en,
    input  logic [PA_W-1:0]       pt_last,
    input  logic [PA_W-1:0]       rgn_base,
    output logic                  hit,
    output logic                  full,
    output logic                  uniform
);
    localparam int AW = PA_W - 2;
    localparam logic [PA_W:0] RGN_BYTES = (PA_W+1)'(1) << REGION_SHIFT;

    logic [PA_W-1:0] lo_b, hi_b, nmask, blk_mask;
    logic [AW:0]     y_val, trail;
    logic            is_tor;
    logic            in_first, in_mid, in_last;
    logic [PA_W:0]   rb_x, re_x, lo_x, hi_x;

    assign lo_b     = {prev_reg, 2'b00};
    assign hi_b     = {addr_reg, 2'b00};
    assign is_tor   = (cfg.mode == AM_TOR);
    // NA4 shifts in a zero so no trailing ones survive: 4-byte region
    assign y_val    = (cfg.mode == AM_NA4) ? {addr_reg, 1'b0} : {addr_reg, 1'b1};
    assign trail    = y_val & ~(y_val + (AW+1)'(1));
    assign nmask    = {~trail[AW-1:0], 2'b00};
    assign blk_mask = ~(PA_W'(RGN_BYTES) - PA_W'(1));

    function automatic logic covers(logic [PA_W-1:0] p, logic tor,
                                    logic [PA_W-1:0] lo, logic [PA_W-1:0] hi,
                                    logic [PA_W-1:0] msk);
        if (tor) return (p >= lo) && (p < hi);
        return ((p ^ hi) & msk) == '0;
    endfunction

    always_comb begin
        in_first = covers(pt_first, is_tor, lo_b, hi_b, nmask);
        in_mid   = pt_mid_en && covers(pt_mid, is_tor, lo_b, hi_b, nmask);
        in_last  = covers(pt_last, is_tor, lo_b, hi_b, nmask);
        hit      = (cfg.mode != AM_OFF) && (in_first || in_mid || in_last);
        full     = in_first && in_last && (in_mid || !pt_mid_en);
    end

    // Uniformity of one aligned block against this entry
    assign rb_x = {1'b0, rgn_base};
    assign re_x = rb_x + RGN_BYTES;
    assign lo_x = {1'b0, lo_b};
    assign hi_x = {1'b0, hi_b};

    always_comb begin
        logic tor_in, tor_out, pow_in, pow_overlap;
        tor_in      = (lo_x <= rb_x) && (re_x <= hi_x);
        tor_out     = (re_x <= lo_x) || (rb_x >= hi_x) || (lo_x >= hi_x);
        pow_in      = (((rgn_base ^ hi_b) & nmask) == '0) && !nmask[REGION_SHIFT-1];
        pow_overlap = ((rgn_base ^ hi_b) & nmask & blk_mask) == '0;
        if (cfg.mode == AM_OFF) uniform = 1'b1;
        else if (is_tor)        uniform = tor_in || tor_out;
        else                    uniform = pow_in || !pow_overlap;
    end

endmodule

// File: rtl/pmp_arbiter.sv
module pmp_arbiter
    import pmp_pkg::*;
#(
    parameter int NUM_ENT = 8
) (
    input  logic [NUM_ENT-1:0] hit,
    input  logic [NUM_ENT-1:0] full,
    input  ent_cfg_t           cfg [NUM_ENT],
    input  logic [1:0]         kind,
    input  logic [1:0]         priv,
    output logic [NUM_ENT-1:0] win,
    output logic               allow
);
    localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    logic          found;
    logic [IW-1:0] sel;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        win   = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!found && hit[i]) begin
                found  = 1'b1;
                sel    = IW'(i);
                win[i] = 1'b1;
            end
        end
    end

    always_comb begin
        if (!found)
            allow = (priv == PRIV_MACHINE);
        else if (!full[sel])
            allow = 1'b0;
        else
            allow = ((priv == PRIV_MACHINE) && !cfg[sel].lock) ||
                    kind_permitted(cfg[sel], kind);
    end

    always_comb begin
        AST_SINGLE_WINNER: assert ($onehot0(win)) else $error("several winners"); // R6
        AST_WINNER_LOWEST: assert (((win - NUM_ENT'(1)) & win & hit) == '0 &&
                                   ((win == '0) || ((hit & (win - NUM_ENT'(1))) == '0)))
            else $error("winner not lowest hit"); // R6
        AST_PARTIAL_DENY: assert (!((win & ~full) != '0) || !allow)
            else $error("partial cover permitted"); // R5
    end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
    import pmp_pkg::*;
#(
    parameter int NUM_ENT      = 8,
    parameter int PA_W         = 34,
    parameter int REGION_SHIFT = 12
) (
    input  logic [PA_W-1:0]              acc_addr,
    input  logic [1:0]                   acc_size,
    input  logic [1:0]                   acc_kind,
    input  logic [1:0]                   acc_priv,
    input  logic [NUM_ENT*8-1:0]         ent_cfg_flat,
    input  logic [NUM_ENT*(PA_W-2)-1:0]  ent_addr_flat,
    input  logic [PA_W-REGION_SHIFT-1:0] rgn_page,
    output logic                         acc_allow,
    output logic                         rgn_uniform
);
    localparam int AW = PA_W - 2;

    ent_cfg_t            cfg [NUM_ENT];
    logic [AW-1:0]       areg [NUM_ENT];
    logic [NUM_ENT-1:0]  hit, full, uni, win;
    logic [PA_W-1:0]     pt_mid, pt_last, rgn_base;
    logic [3:0]          nbytes;
    logic [NUM_ENT-1:0]  cfg_spare_unused;

    assign nbytes   = 4'd1 << acc_size;
    assign pt_last  = acc_addr + PA_W'(nbytes - 4'd1);
    assign pt_mid   = acc_addr + PA_W'(4);
    assign rgn_base = {rgn_page, {REGION_SHIFT{1'b0}}};

    generate
        for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
            logic [AW-1:0] prev;
            assign cfg[i]  = ent_cfg_t'(ent_cfg_flat[i*8 +: 8]);
            assign areg[i] = ent_addr_flat[i*AW +: AW];
            assign cfg_spare_unused[i] = ^cfg[i].spare;
            if (i == 0) begin : g_base
                assign prev = '0;
            end else begin : g_chain
                assign prev = ent_addr_flat[(i-1)*AW +: AW];
            end
            pmp_entry_match #(.PA_W(PA_W), .REGION_SHIFT(REGION_SHIFT)) u_match (
                .cfg       (cfg[i]),
                .addr_reg  (areg[i]),
                .prev_reg  (prev),
                .pt_first  (acc_addr),
                .pt_mid    (pt_mid),
                .pt_mid_en (acc_size == 2'd3),
                .pt_last   (pt_last),
                .rgn_base  (rgn_base),
                .hit       (hit[i]),
                .full      (full[i]),
                .uniform   (uni[i])
            );
        end
    endgenerate

    pmp_arbiter #(.NUM_ENT(NUM_ENT)) u_arb (
        .hit   (hit),
        .full  (full),
        .cfg   (cfg),
        .kind  (acc_kind),
        .priv  (acc_priv),
        .win   (win),
        .allow (acc_allow)
    );

    assign rgn_uniform = &uni;

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            AST_OFF_NO_HIT: assert (!(cfg[i].mode == AM_OFF && hit[i]))
                else $error("disabled entry matched"); // R1
        end
        AST_NOMATCH_DEFAULT: assert (hit != '0 || acc_allow == (acc_priv == PRIV_MACHINE))
            else $error("default decision wrong"); // R9
        AST_WIN_WHEN_HIT: assert ((hit == '0) == (win == '0))
            else $error("hit without winner"); // R6
    end

endmodule

// File: tb/pmp_guard_test.sv
`timescale 1ns/1ps
module pmp_guard_test;
    localparam int NE   = 8;
    localparam int PA_W = 34;
    localparam int RS   = 6;
    localparam int AW   = PA_W - 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [PA_W-1:0]      acc_addr;
    logic [1:0]           acc_size, acc_kind, acc_priv;
    logic [NE*8-1:0]      cfg_flat;
    logic [NE*AW-1:0]     addr_flat;
    logic [PA_W-RS-1:0]   rgn_page;
    logic                 acc_allow, rgn_uniform;

    pmp_guard #(.NUM_ENT(NE), .PA_W(PA_W), .REGION_SHIFT(RS)) uut (
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
        .acc_priv(acc_priv), .ent_cfg_flat(cfg_flat), .ent_addr_flat(addr_flat),
        .rgn_page(rgn_page), .acc_allow(acc_allow), .rgn_uniform(rgn_uniform)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0]          cfgs [NE];
    longint unsigned     regs [NE];

    task automatic check(string tag, logic got, logic exp, string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s addr=%0h size=%0d kind=%0d priv=%0d: got %0b expected %0b",
                     tag, what, acc_addr, acc_size, acc_kind, acc_priv, got, exp);
        end
    endtask

    task automatic load_cfg();
        for (int i = 0; i < NE; i++) begin
            cfg_flat[i*8 +: 8]    = cfgs[i];
            addr_flat[i*AW +: AW] = AW'(regs[i]);
        end
    endtask

    // Byte range [lo, hi) of an entry from the requirements
    function automatic void span(int e, output longint unsigned lo, output longint unsigned hi);
        int m = cfgs[e][4:3];
        if (m == 1) begin
            lo = (e == 0) ? 0 : regs[e-1] * 4;
            hi = regs[e] * 4;
        end else if (m == 2) begin
            lo = regs[e] * 4;
            hi = lo + 4;
        end else begin
            int k = 0;
            longint unsigned sz;
            while (k < AW && regs[e][k]) k++;
            sz = longint'(8) << k;
            lo = (regs[e] * 4) & ~(sz - 1);
            hi = lo + sz;
        end
    endfunction

    function automatic logic model_allow(longint unsigned a, int sz, int kind, int priv,
                                         output string tag);
        for (int e = 0; e < NE; e++) begin
            longint unsigned lo, hi;
            bit anyb = 0, allb = 1;
            if (cfgs[e][4:3] == 0) continue;
            span(e, lo, hi);
            for (int j = 0; j < (1 << sz); j++) begin
                bit inb = (a + j >= lo) && (a + j < hi);
                anyb |= inb;
                allb &= inb;
            end
            if (!anyb) continue;
            if (!allb) begin tag = "R5"; return 1'b0; end
            if (priv == 3) begin
                tag = "R8";
                if (!cfgs[e][7]) return 1'b1;
            end else tag = "R7";
            return cfgs[e][kind];
        end
        tag = "R9";
        return priv == 3;
    endfunction

    function automatic logic model_uniform(longint unsigned page);
        longint unsigned rb = page << RS;
        longint unsigned re = rb + (longint'(1) << RS);
        for (int e = 0; e < NE; e++) begin
            longint unsigned lo, hi;
            if (cfgs[e][4:3] == 0) continue;
            span(e, lo, hi);
            if (hi <= lo) continue;
            if ((rb >= lo && re <= hi) || re <= lo || rb >= hi) continue;
            return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic probe(longint unsigned a, int sz, int kind, int priv);
        @(negedge clk);
        acc_addr = PA_W'(a);
        acc_size = 2'(sz);
        acc_kind = 2'(kind);
        acc_priv = 2'(priv);
        rgn_page = (PA_W-RS)'(a >> RS);
        @(posedge clk);
    endtask

    task automatic directed(string tag, longint unsigned a, int kind, logic exp);
        probe(a, 0, kind, 0);
        check(tag, acc_allow, exp, "directed");
    endtask

    task automatic set_layout(int c);
        for (int i = 0; i < NE; i++) begin cfgs[i] = 8'h00; regs[i] = 0; end
        case (c)
            1: begin
                cfgs[0] = 8'h89; regs[0] = 'h10;  // TOR [0,0x40) R, locked
                cfgs[1] = 8'h12; regs[1] = 'h14;  // NA4 0x50 W
                cfgs[2] = 8'h9D; regs[2] = 'h19;  // NAPOT 0x60..0x6F RX, locked
                cfgs[3] = 8'h0F; regs[3] = 'h30;  // TOR [0x64,0xC0) RWX
                cfgs[4] = 8'h9A; regs[4] = 'h2F;  // NAPOT 0x80..0xFF W, locked
                cfgs[5] = 8'h07; regs[5] = 'h47;  // disabled, bits set
            end
            2: begin
                cfgs[0] = 8'h90; regs[0] = 'h08;  // NA4 0x20, no perms, locked
                cfgs[1] = 8'h1F; regs[1] = 'h07;  // NAPOT 0..0x3F RWX
                cfgs[2] = 8'h0F; regs[2] = 'h00;  // TOR empty
                cfgs[3] = 8'h09; regs[3] = 'h40;  // TOR [0,0x100) R
            end
            3: begin
                cfgs[0] = 8'h8E; regs[0] = 'h21;  // TOR [0,0x84) WX, locked
                cfgs[1] = 8'h14; regs[1] = 'h2A;  // NA4 0xA8 X
                cfgs[7] = 8'h19; regs[7] = 'hFFFF_FFFF; // NAPOT everything R
            end
            default: ;
        endcase
        load_cfg();
    endtask

    initial begin
        acc_addr = '0; acc_size = '0; acc_kind = '0; acc_priv = '0; rgn_page = '0;
        set_layout(0);
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Initial state with every entry off: user denied, machine allowed, uniform
        probe(0, 0, 0, 0);
        check("R9", acc_allow, 1'b0, "all off user");
        check("R10", rgn_uniform, 1'b1, "all off uniform");
        probe(0, 0, 0, 3);
        check("R9", acc_allow, 1'b1, "all off machine");

        // Directed points on layout 1
        set_layout(1);
        directed("R2", 'h3F, 0, 1'b1);
        directed("R2", 'h40, 0, 1'b0);
        directed("R2", 'h64, 0, 1'b1);   // lower bound from entry 2's register
        directed("R2", 'h63, 1, 1'b0);
        directed("R3", 'h50, 1, 1'b1);
        directed("R3", 'h54, 1, 1'b0);
        directed("R4", 'h60, 2, 1'b1);
        directed("R4", 'h5F, 2, 1'b0);
        directed("R6", 'h90, 1, 1'b1);   // entry 3 wins over entry 4
        directed("R6", 'hC0, 1, 1'b1);
        directed("R6", 'hC0, 0, 1'b0);
        directed("R1", 'h100, 0, 1'b0);  // disabled entry 5 would cover it
        probe('h3E, 2, 0, 0);
        check("R5", acc_allow, 1'b0, "straddles TOR end");
        probe('h4F, 3, 1, 0);            // middle granule hits NA4 only
        check("R5", acc_allow, 1'b0, "8-byte over NA4");
        probe('h00, 0, 1, 3);
        check("R8", acc_allow, 1'b0, "locked TOR store machine");
        directed("R7", 'h68, 2, 1'b1);

        // Exhaustive sweep over several layouts
        for (int c = 0; c < 4; c++) begin
            set_layout(c);
            for (int a = 0; a < 256; a++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int k = 0; k < 3; k++) begin
                        for (int pv = 0; pv < 4; pv += 3) begin
                            string tag;
                            logic exp;
                            exp = model_allow(longint'(a), sz, k, pv, tag);
                            probe(longint'(a), sz, k, pv);
                            check(tag, acc_allow, exp, "sweep");
                        end
                    end
                end
                check("R10", rgn_uniform, model_uniform(longint'(a) >> RS), "uniform");
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule